// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM with Zero Bus Turnaround

This block is a synthesizable behavioural model of a pipelined synchronous static RAM. Its data bus can change direction on any clock, from read to write or back, without an idle cycle. It achieves this by giving write data the same two-edge pipeline delay as read data. Every input is registered on the rising clock edge. One control input picks, on each cycle, between loading a fresh external address and stepping an internal 2-bit burst counter. The counter steps in either linear or interleaved order.

A host starts a cycle by loading an address. The cycle is a read or a write when all three chip selects are active, and a deselect when they are not. Burst beats then follow by holding the advance input high. Each beat inherits its cycle kind from the load and takes a fresh set of per-byte write strobes. A hold input freezes the whole pipeline, including the output registers. The shared bus is modelled as a write-data input, a read-data output and an output-enable flag.

Top module: `zb_sram`

## Requirements
- R1: After reset, `rdata_oe` is low and `rdata` is zero, and the pipeline holds no read or write.
- R2: While `hold` is high, every other input is ignored and `rdata`, `rdata_oe` and all pipeline state keep their values. A write in its data phase waits for the next edge with `hold` low.
- R3: A load edge (`hold` low, `adv` low) captures `addr`. If the chip is selected and `wr_n` is low, the cycle is a write. Its `wdata` is captured at the second enabled edge after the load edge.
- R4: If the chip is selected and `wr_n` is high, the load begins a read. In the window between the first and the second enabled edge after the address edge, `rdata_oe` is high and `rdata` holds the addressed word.
- R5: With `order_ilv` low at the load edge, beat n of the burst uses a low address pair of (base[1:0] + n) mod 4.
- R6: With `order_ilv` high at the load edge, beat n uses base[1:0] XOR n.
- R7: A continue edge (`hold` low, `adv` high) steps the count by one. It keeps the upper address bits and the cycle kind of the load. It ignores `addr`, `wr_n`, the chip selects and `order_ilv`.
- R8: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at the load edge. Otherwise that cycle and its continue beats drive nothing (`rdata_oe` low) and write nothing.
- R9: Reads and writes may alternate on every enabled edge. A read loaded one edge after a write to the same word returns the newly written bytes.
- R10: `lane_wr_n` is active low and is sampled on every beat. Lane i covers `wdata` bits [9i+8:9i]. Only lanes whose strobe is 0 are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | High freezes the whole block |
| adv | input | 1 | 0 loads a new address, 1 steps the burst |
| wr_n | input | 1 | 0 selects write on a load edge |
| lane_wr_n | input | 4 | Active-low per-lane write strobes |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| order_ilv | input | 1 | 1 interleaved, 0 linear burst order |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data for the write in its data phase |
| rdata | output | 36 | Read data |
| rdata_oe | output | 1 | High while `rdata` is a valid read |

## Verification
The full array is first written with linear bursts from rotating start offsets, then read back with interleaved bursts. This separates the two orders: a swapped or wrong order returns data from the wrong word. Single-beat writes alternate with reads of the same word to exercise forwarding at the turnaround, and each write uses a different lane strobe pattern to isolate lane errors. Hold cycles inserted inside bursts and in data phases show whether the pipeline and the output freeze. Loads with each of the seven non-selecting chip-select combinations, with writes attempted and later read back, show that deselected cycles neither drive the bus nor change storage.

// File: rtl/zb_pkg.sv
package zb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address pair of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/zb_addr_stage.sv
module zb_addr_stage
  import zb_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          adv,
  input  logic          wr_n,
  input  logic [NB-1:0] lane_wr_n,
  input  logic          sel_ok,
  input  logic          order_ilv,
  input  logic [AW-1:0] addr,
  output op_e           s1_op,
  output logic [AW-1:0] s1_base,
  output logic [1:0]    s1_cnt,
  output logic [NB-1:0] s1_ben,
  output logic [AW-1:0] s1_addr
);
  logic ilv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_base <= '0;
      s1_cnt  <= '0;
      s1_ben  <= '1;
      ilv_q   <= 1'b0;
    end else if (!hold) begin
      s1_ben <= lane_wr_n;
      if (!adv) begin
        s1_op   <= !sel_ok ? OP_IDLE : (wr_n ? OP_RD : OP_WR);
        s1_base <= addr;
        s1_cnt  <= '0;
        ilv_q   <= order_ilv;
      end else begin
        s1_cnt <= s1_cnt + 2'd1;
      end
    end
  end

  assign s1_addr = {s1_base[AW-1:2], beat_low(s1_base[1:0], s1_cnt, ilv_q)};
endmodule

// File: rtl/zb_data_stage.sv
module zb_data_stage
  import zb_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  op_e           s1_op,
  input  logic [AW-1:0] s1_addr,
  input  logic [NB-1:0] s1_ben,
  output op_e           s2_op,
  output logic [AW-1:0] s2_addr,
  output logic [NB-1:0] s2_ben
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_ben  <= '1;
    end else if (!hold) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_ben  <= s1_ben;
    end
  end
endmodule

// File: rtl/zb_store.sv
module zb_store
  import zb_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  op_e              s1_op,
  input  logic [AW-1:0]    s1_addr,
  input  op_e              s2_op,
  input  logic [AW-1:0]    s2_addr,
  input  logic [NB-1:0]    s2_ben,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] rdata,
  output logic             rdata_oe,
  output logic             mem_we,
  output logic             fwd_hit
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wr_word;
  logic [DW-1:0] rd_word;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NB-1:0] ben_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < NB; i++)
      if (!ben_n[i]) r[i*BW +: BW] = new_w[i*BW +: BW];
    return r;
  endfunction

  assign mem_we  = !hold && (s2_op == OP_WR);
  assign wr_word = lane_merge(mem[s2_addr], wdata, s2_ben);
  assign fwd_hit = (s2_op == OP_WR) && (s2_addr == s1_addr);
  assign rd_word = fwd_hit ? wr_word : mem[s1_addr];

  always_ff @(posedge clk) begin
    if (mem_we) mem[s2_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else if (!hold) begin
      rdata_oe <= (s1_op == OP_RD);
      rdata    <= (s1_op == OP_RD) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/zb_sram.sv
module zb_sram
  import zb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold,
  input  logic                    adv,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    order_ilv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  logic              sel_ok;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_base, s1_addr, s2_addr;
  logic [1:0]        s1_cnt;
  logic [LANES-1:0]  s1_ben, s2_ben;
  logic              mem_we, fwd_hit;

  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  zb_addr_stage #(.AW(ADDR_W), .NB(LANES)) u_addr (
    .clk(clk), .rst_n(rst_n), .hold(hold), .adv(adv), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .sel_ok(sel_ok), .order_ilv(order_ilv),
    .addr(addr), .s1_op(s1_op), .s1_base(s1_base), .s1_cnt(s1_cnt),
    .s1_ben(s1_ben), .s1_addr(s1_addr)
  );

  zb_data_stage #(.AW(ADDR_W), .NB(LANES)) u_data (
    .clk(clk), .rst_n(rst_n), .hold(hold), .s1_op(s1_op),
    .s1_addr(s1_addr), .s1_ben(s1_ben), .s2_op(s2_op),
    .s2_addr(s2_addr), .s2_ben(s2_ben)
  );

  zb_store #(.AW(ADDR_W), .NB(LANES), .BW(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .hold(hold), .s1_op(s1_op),
    .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
    .s2_ben(s2_ben), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .mem_we(mem_we), .fwd_hit(fwd_hit)
  );
endmodule

// File: rtl/zb_sram_chk.sv
module zb_sram_chk
  import zb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          adv,
  input logic [AW-1:0] addr,
  input op_e           s1_op,
  input logic [AW-1:0] s1_base,
  input logic [1:0]    s1_cnt,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe
);
  // R2: a held edge changes nothing visible
  a_r2_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(rdata) && $stable(rdata_oe) && $stable(s1_base) && $stable(s1_cnt));

  // R3: a load edge captures the external address and clears the count
  a_r3_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !adv) |=> (s1_base == $past(addr)) && (s1_cnt == 2'd0));

  // R7: a continue edge steps the count and keeps base and kind
  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && adv) |=> (s1_cnt == 2'($past(s1_cnt) + 2'd1)) &&
                       (s1_base == $past(s1_base)) && (s1_op == $past(s1_op)));

  // R4: a read in the address stage reaches the bus at the next enabled edge
  a_r4_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && s1_op == OP_RD) |=> rdata_oe);

  // R8: deselect or write cycles never drive the bus
  a_r8_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && s1_op != OP_RD) |=> !rdata_oe);
endmodule

bind zb_sram zb_sram_chk #(.AW(ADDR_W), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .adv(adv), .addr(addr),
  .s1_op(s1_op), .s1_base(s1_base), .s1_cnt(s1_cnt),
  .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/tb_zb_sram.sv
module tb_zb_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b0, adv = 1'b0, wr_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, order_ilv = 1'b0;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rdata_oe;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  zb_sram dut (
    .clk(clk), .rst_n(rst_n), .hold(hold), .adv(adv), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .order_ilv(order_ilv), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // bench model: kind 0 idle, 1 read, 2 write
  typedef struct {
    int         kind;
    logic [7:0] a;
    logic [3:0] ben;
    int         serial;
    string      tag;
  } ent_t;

  logic [35:0] ref_mem [256];
  ent_t p1, p2;
  int   b_kind = 0;
  logic [7:0] b_base = '0;
  logic [1:0] b_cnt = '0;
  logic b_ilv = 1'b0;
  int   serial_n = 0;

  function automatic logic [35:0] wgen(input int s, input logic [7:0] a);
    logic [35:0] v;
    v = 36'(unsigned'(s)) * 36'd2654435761;
    return v ^ {a, a[3:0], a, a, a};
  endfunction

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual oe/data=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input bit h, input bit ad, input bit wn, input logic [3:0] ben,
                      input logic [2:0] ce, input bit ilv, input logic [7:0] a,
                      input string tag);
    ent_t n;
    @(negedge clk);
    // data-phase window of the op in p2
    if (p2.kind == 1)
      check(p2.tag, {rdata_oe, rdata}, {1'b1, ref_mem[p2.a]});
    else
      check(p2.tag, {rdata_oe, 36'd0}, 37'd0);
    hold = h; adv = ad; wr_n = wn; lane_wr_n = ben;
    {sel_a_n, sel_b, sel_c_n} = ce; order_ilv = ilv; addr = a;
    wdata = (p2.kind == 2) ? wgen(p2.serial, p2.a) : ~36'd0;
    @(posedge clk);
    if (!h) begin
      if (p2.kind == 2)
        for (int i = 0; i < 4; i++)
          if (!p2.ben[i]) ref_mem[p2.a][i*9 +: 9] = wdata[i*9 +: 9];
      if (!ad) begin
        b_kind = (ce != 3'b010) ? 0 : (wn ? 1 : 2);
        b_base = a; b_cnt = 2'd0; b_ilv = ilv;
      end else begin
        b_cnt = b_cnt + 2'd1;
      end
      n.kind = b_kind;
      n.a    = {b_base[7:2], b_ilv ? (b_base[1:0] ^ b_cnt) : 2'((b_base[1:0] + b_cnt) & 2'd3)};
      n.ben  = ben;
      n.serial = serial_n++;
      n.tag  = tag;
      p2 = p1;
      p1 = n;
    end else begin
      // a held read repeats its check; tag the freeze
      p2.tag = (p2.kind == 1) ? "R2 held read" : p2.tag;
    end
  endtask

  task automatic load(input bit wr, input logic [7:0] a, input logic [3:0] ben,
                      input bit ilv, input string tag);
    tick(1'b0, 1'b0, !wr, ben, 3'b010, ilv, a, tag);
  endtask

  // continue beat: wr_n, selects, mode and address are junk on purpose (R7)
  task automatic cont(input logic [3:0] ben, input string tag);
    tick(1'b0, 1'b1, ~wr_n, ben, 3'b101, ~order_ilv, 8'hA5 ^ addr, tag);
  endtask

  task automatic stall(input string tag);
    tick(1'b1, 1'b0, 1'b0, 4'h0, 3'b010, 1'b1, 8'h3C, tag);
  endtask

  task automatic idle(input string tag);
    tick(1'b0, 1'b0, 1'b1, 4'hF, 3'b110, 1'b0, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    p1.kind = 0; p1.a = 0; p1.ben = 4'hF; p1.serial = 0; p1.tag = "R1";
    p2 = p1;
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 reset", {rdata_oe, rdata}, 37'd0);

    // R5 R3: fill array with linear write bursts, rotating start
    for (int g = 0; g < 64; g++) begin
      load(1'b1, 8'(g*4 + (g % 4)), 4'h0, 1'b0, "R5 linear write");
      for (int b = 0; b < 3; b++) cont(4'h0, "R5 linear write");
    end
    // R6 R4: read back with interleaved bursts
    for (int g = 0; g < 64; g++) begin
      load(1'b0, 8'(g*4 + ((g + 1) % 4)), 4'hF, 1'b1, "R6 interleaved read");
      for (int b = 0; b < 3; b++) cont(4'hF, "R6 interleaved read");
    end
    // R6 R5: interleaved write, linear read-back
    load(1'b1, 8'h23, 4'h0, 1'b1, "R6 interleaved write");
    for (int b = 0; b < 3; b++) cont(4'h0, "R6 interleaved write");
    load(1'b0, 8'h22, 4'hF, 1'b0, "R5 linear read");
    for (int b = 0; b < 3; b++) cont(4'hF, "R5 linear read");

    // R9 R10: alternate write then read of the same word, varying lanes
    for (int k = 0; k < 32; k++) begin
      load(1'b1, 8'(8'h80 + k), 4'(k), k[0], "R10 lane write");
      load(1'b0, 8'(8'h80 + k), 4'hF, 1'b0, "R9 read after write");
    end
    // R9: read then write same word, then read again
    for (int k = 0; k < 8; k++) begin
      load(1'b0, 8'(8'h90 + k), 4'hF, 1'b0, "R9 read before write");
      load(1'b1, 8'(8'h90 + k), 4'h0, 1'b0, "R9 write");
      load(1'b0, 8'(8'h90 + k), 4'hF, 1'b0, "R9 read new");
    end
    // R10: burst with per-beat lane strobes
    load(1'b1, 8'h4C, 4'b1110, 1'b0, "R10 per-beat lanes");
    cont(4'b1101, "R10 per-beat lanes");
    cont(4'b1011, "R10 per-beat lanes");
    cont(4'b0111, "R10 per-beat lanes");
    load(1'b0, 8'h4C, 4'hF, 1'b0, "R10 lane readback");
    for (int b = 0; b < 3; b++) cont(4'hF, "R10 lane readback");

    // R2: holds inside bursts and in data phases
    load(1'b1, 8'h61, 4'h0, 1'b1, "R2 write with holds");
    stall("R2");
    cont(4'h0, "R2 write with holds");
    stall("R2"); stall("R2");
    cont(4'h0, "R2 write with holds");
    cont(4'h0, "R2 write with holds");
    stall("R2");
    load(1'b0, 8'h61, 4'hF, 1'b1, "R2 read with holds");
    cont(4'hF, "R2 read with holds");
    stall("R2");
    cont(4'hF, "R2 read with holds");
    stall("R2"); stall("R2");
    cont(4'hF, "R2 read with holds");
    idle("R2 drain");

    // R8: every non-selecting chip-select combination
    for (int v = 0; v < 8; v++) begin
      if (v != 2) begin
        tick(1'b0, 1'b0, 1'b0, 4'h0, 3'(v), 1'b0, 8'(8'hA0 + v*4), "R8 deselect write");
        cont(4'h0, "R8 deselect burst");
        tick(1'b0, 1'b0, 1'b1, 4'hF, 3'(v), 1'b0, 8'(8'hA0 + v*4), "R8 deselect read");
        cont(4'hF, "R8 deselect burst");
        load(1'b0, 8'(8'hA0 + v*4), 4'hF, 1'b0, "R8 storage unchanged");
        cont(4'hF, "R8 storage unchanged");
      end
    end
    idle("R8 drain"); idle("R8 drain"); idle("R8 drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule